// File: doc/BRIEF.md
# Dual Count-Up Limit Timer

This block holds two independent counter/timers behind a simple register port. A prescaler turns the system clock into a one-cycle tick at a fixed rate. On each tick an active timer counts up by one. When the next step would reach the programmed limit, the counter returns to 1 and sets a sticky limit-reached flag. Each timer drives its own interrupt line from that flag. Timer 0 drives the low-priority line and timer 1 drives the high-priority line.

Because the count restarts at 1 and never shows 0, software that wants an event every N ticks writes N+1 as the limit. Each counter readback puts the flag and the count value in one 32-bit word. A second limit address changes the limit without restarting the count. The normal limit address restarts the count.

Software clears the flag by reading either limit address. Each timer can be placed in user mode, where a run bit starts and stops it. Outside user mode the timer runs whenever its limit is non-zero. A parameter selects a finer variant: a 22-bit field at bit 9 with a 500 ns tick, instead of a 21-bit field at bit 10 with a 1 us tick.

Top module: `tmr_limit_pair`

## Requirements
- R1: After a synchronous active-low reset, both counts are 1, both limits are 0, both flags and both interrupts are low, and the run and mode bits are 0.
- R2: The prescaler asserts a one-cycle tick every DIV clock cycles, where DIV = CLK_HZ / tick rate. The tick rate is 1 MHz by default and 2 MHz in the fine variant. Counts advance only on ticks.
- R3: On a tick, an active timer compares count+1 with the limit. If count+1 >= limit, the count becomes 1 and the flag is set. Otherwise the count increments by one. A limit of N+1 (N >= 1) therefore gives one event every N ticks.
- R4: A timer whose limit is 0 is inactive. Its count holds and it raises no event.
- R5: Readback layout of the limit and count words: bit 31 is the flag, the field occupies bits 30:10 (bits 30:9 in the fine variant), and every lower bit reads 0. On writes, the limit is taken from the same field position.
- R6: A write to word 0 (limit) loads the limit and sets the count to 1. An event that would fall in that same cycle is cancelled.
- R7: A write to word 2 (limit alias) loads the limit and leaves the count unchanged.
- R8: Word 0 and word 2 read back {flag, limit}. Reading either one clears that timer's flag, unless an event sets it in the same cycle. Reading word 1, {flag, count}, does not clear the flag.
- R9: irq_lo always equals timer 0's flag and irq_hi always equals timer 1's flag.
- R10: Word 3 bit 0 is the run bit and word 4 bit 0 is the user-mode bit. Both read back in bit 0. In user mode the timer advances only while run is 1. A stopped timer holds its count and raises no event.
- R11: Byte address bit 5 selects the timer and bits 4:2 select the word. Words 5 to 7 read as 0, and writes to them or to word 1 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_rd | input | 1 | Read strobe; side effects take place at the clock edge |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 6 | Byte address: bit 5 selects the timer, bits 4:2 select the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed word (combinational) |
| irq_lo | output | 1 | Timer 0 interrupt, low priority |
| irq_hi | output | 1 | Timer 1 interrupt, high priority |

## Verification
The checker verifies on every cycle that neither count ever shows 0. It also checks that an interrupt rises only on the cycle after a tick and that a count stays put when the previous cycle had neither a tick nor a write. Two further checks cover the limit write and the limit read: a limit write leaves the count at 1, and a limit read with no tick drops the interrupt. The bench's scenarios and its cycle-accurate model cover the rest: the exact event period for a given limit, the alias write leaving the count untouched, the inactive zero limit, the difference between user and free-running mode, and the readback layout.

// File: rtl/tmr_pkg.sv
// Package: shared word indexes and per-timer access strobes for the
// dual limit timer. Assumes a word-addressed map of eight words per timer.
package tmr_pkg;

    // Word index within one timer's register window (byte address bits 4:2)
    typedef enum logic [2:0] {
        WORD_LIMIT    = 3'd0,
        WORD_COUNT    = 3'd1,
        WORD_LIMIT_NR = 3'd2,
        WORD_RUN      = 3'd3,
        WORD_MODE     = 3'd4
    } tmr_word_e;

    // One-cycle access strobes decoded for a single timer
    typedef struct packed {
        logic lim_wr;     // write to the restarting limit word
        logic lim_nr_wr;  // write to the non-restarting limit alias
        logic lim_rd;     // read of either limit word (clears flag)
        logic run_wr;     // write to the run word
        logic mode_wr;    // write to the mode word
    } tmr_strobe_t;

endpackage

// File: rtl/tmr_prescaler.sv
// Module: tmr_prescaler
// Produces a one-cycle tick enable every DIV clock cycles. The first tick
// comes DIV cycles after reset is released. DIV of 1 gives a tick on
// every cycle.
module tmr_prescaler #(
    parameter int DIV = 200
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);

    generate
        if (DIV <= 1) begin : g_every_cycle
            logic unused_clkrst;
            assign unused_clkrst = clk ^ rst_n;
            assign tick = 1'b1;
        end else begin : g_divider
            localparam int PW = $clog2(DIV);
            localparam logic [PW-1:0] LAST = PW'(DIV - 1);
            logic [PW-1:0] phase;

            // Free-running phase counter that wraps after DIV cycles
            always_ff @(posedge clk) begin
                if (!rst_n)
                    phase <= '0;
                else if (phase == LAST)
                    phase <= '0;
                else
                    phase <= phase + 1'b1;
            end

            assign tick = (phase == LAST);
        end
    endgenerate

endmodule

// File: rtl/tmr_decode.sv
// Module: tmr_decode
// Turns a read or write at a byte address into per-timer strobes. Bits 1:0
// are ignored, bits 4:2 pick the word and the bits above pick the timer.
// Assumes rd and wr are one-cycle qualified strobes.
module tmr_decode
    import tmr_pkg::*;
#(
    parameter int NT = 2,
    parameter int AW = 6
) (
    input  logic          rd,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    output tmr_strobe_t   str [NT]
);

    localparam int SW = AW - 5;

    logic [2:0]    word;
    logic [SW-1:0] sel;
    logic [1:0]    unused_byte;

    assign word        = addr[4:2];
    assign sel         = addr[AW-1:5];
    assign unused_byte = addr[1:0];

    generate
        for (genvar i = 0; i < NT; i++) begin : g_timer
            logic hit;
            assign hit = (sel == SW'(i));

            // Strobes for timer i, qualified by its select
            always_comb begin
                str[i].lim_wr    = hit && wr && (word == WORD_LIMIT);
                str[i].lim_nr_wr = hit && wr && (word == WORD_LIMIT_NR);
                str[i].lim_rd    = hit && rd && ((word == WORD_LIMIT) ||
                                                 (word == WORD_LIMIT_NR));
                str[i].run_wr    = hit && wr && (word == WORD_RUN);
                str[i].mode_wr   = hit && wr && (word == WORD_MODE);
            end
        end
    endgenerate

endmodule

// File: rtl/tmr_unit.sv
// Module: tmr_unit
// One count-up timer: count, limit, sticky flag, run and user-mode bits.
// Counts on tick when active and wraps to 1 when count+1 reaches the limit.
// Assumes the strobes come from tmr_decode and at most one write per cycle.
module tmr_unit
    import tmr_pkg::*;
#(
    parameter int CW = 21
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  tmr_strobe_t   str,
    input  logic [CW-1:0] wfield,
    input  logic          wbit,
    output logic [CW-1:0] cnt,
    output logic [CW-1:0] lim,
    output logic          flag,
    output logic          run,
    output logic          umode
);

    localparam logic [CW-1:0] ONE = CW'(1);

    logic        active;
    logic        at_limit;
    logic        wrap_event;
    logic [CW:0] next_up;

    assign active     = (lim != '0) && (!umode || run);
    assign next_up    = {1'b0, cnt} + 1'b1;
    assign at_limit   = (next_up >= {1'b0, lim});
    assign wrap_event = tick && active && at_limit && !str.lim_wr;

    // Count: restart on limit write, else step or wrap on an active tick
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= ONE;
        else if (str.lim_wr)
            cnt <= ONE;
        else if (tick && active)
            cnt <= at_limit ? ONE : next_up[CW-1:0];
    end

    // Limit: loaded from either limit address
    always_ff @(posedge clk) begin
        if (!rst_n)
            lim <= '0;
        else if (str.lim_wr || str.lim_nr_wr)
            lim <= wfield;
    end

    // Flag: set by a wrap, cleared by a limit read; set wins
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag <= 1'b0;
        else if (wrap_event)
            flag <= 1'b1;
        else if (str.lim_rd)
            flag <= 1'b0;
    end

    // Run and user-mode control bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run   <= 1'b0;
            umode <= 1'b0;
        end else begin
            if (str.run_wr)
                run <= wbit;
            if (str.mode_wr)
                umode <= wbit;
        end
    end

endmodule

// File: rtl/tmr_limit_pair.sv
// Module: tmr_limit_pair (top)
// Two count-up limit timers that share one prescaler and one register
// port. Timer 0 drives irq_lo and timer 1 drives irq_hi. FINE=1 selects
// a 22-bit field at bit 9 with a 500 ns tick; FINE=0 selects a 21-bit
// field at bit 10 with a 1 us tick. Reads are combinational.
module tmr_limit_pair
    import tmr_pkg::*;
#(
    parameter int CLK_HZ = 200_000_000,
    parameter bit FINE   = 1'b0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_rd,
    input  logic        bus_wr,
    input  logic [5:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq_lo,
    output logic        irq_hi
);

    localparam int NT      = 2;
    localparam int AW      = 6;
    localparam int CW      = FINE ? 22 : 21;
    localparam int LSB     = 31 - CW;
    localparam int RATE_HZ = FINE ? 2_000_000 : 1_000_000;
    localparam int DIV     = (CLK_HZ / RATE_HZ) < 1 ? 1 : (CLK_HZ / RATE_HZ);

    logic              tick;
    tmr_strobe_t       str    [NT];
    logic [CW-1:0]     cnt_q  [NT];
    logic [CW-1:0]     lim_q  [NT];
    logic              flag_q [NT];
    logic              run_q  [NT];
    logic              mode_q [NT];
    logic [CW-1:0]     wfield;
    logic              unused_wbits;
    logic [31:0]       cnt_word0;
    logic [31:0]       cnt_word1;

    assign wfield       = bus_wdata[30:LSB];
    assign unused_wbits = ^{bus_wdata[31], bus_wdata[LSB-1:1]};

    tmr_prescaler #(.DIV(DIV)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    tmr_decode #(.NT(NT), .AW(AW)) u_dec (
        .rd   (bus_rd),
        .wr   (bus_wr),
        .addr (bus_addr),
        .str  (str)
    );

    generate
        for (genvar i = 0; i < NT; i++) begin : g_unit
            tmr_unit #(.CW(CW)) u_tmr (
                .clk    (clk),
                .rst_n  (rst_n),
                .tick   (tick),
                .str    (str[i]),
                .wfield (wfield),
                .wbit   (bus_wdata[0]),
                .cnt    (cnt_q[i]),
                .lim    (lim_q[i]),
                .flag   (flag_q[i]),
                .run    (run_q[i]),
                .umode  (mode_q[i])
            );
        end
    endgenerate

    assign irq_lo = flag_q[0];
    assign irq_hi = flag_q[1];

    // Packed count words, also observed by the bound checker
    assign cnt_word0 = {flag_q[0], cnt_q[0], {LSB{1'b0}}};
    assign cnt_word1 = {flag_q[1], cnt_q[1], {LSB{1'b0}}};

    // Read mux: pick the timer by bit 5 and the word by bits 4:2
    always_comb begin
        logic s;
        s = bus_addr[5];
        bus_rdata = '0;
        case (bus_addr[4:2])
            WORD_LIMIT, WORD_LIMIT_NR:
                bus_rdata = {flag_q[s], lim_q[s], {LSB{1'b0}}};
            WORD_COUNT:
                bus_rdata = s ? cnt_word1 : cnt_word0;
            WORD_RUN:
                bus_rdata = {31'd0, run_q[s]};
            WORD_MODE:
                bus_rdata = {31'd0, mode_q[s]};
            default:
                bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/tmr_limit_pair_chk.sv
// Module: tmr_limit_pair_chk
// Assertion checker bound to tmr_limit_pair. It observes the ports, the
// shared tick and the packed count words. Field checks cover both layouts.
module tmr_limit_pair_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_rd,
    input logic        bus_wr,
    input logic [5:0]  bus_addr,
    input logic        irq_lo,
    input logic        irq_hi,
    input logic        tick,
    input logic [31:0] cnt_word0,
    input logic [31:0] cnt_word1
);

    logic t0_lim_rd, t1_lim_rd, t0_lim_wr, t1_lim_wr;

    assign t0_lim_rd = bus_rd && !bus_addr[5] && ((bus_addr[4:2] == 3'd0) || (bus_addr[4:2] == 3'd2));
    assign t1_lim_rd = bus_rd &&  bus_addr[5] && ((bus_addr[4:2] == 3'd0) || (bus_addr[4:2] == 3'd2));
    assign t0_lim_wr = bus_wr && !bus_addr[5] && (bus_addr[4:2] == 3'd0);
    assign t1_lim_wr = bus_wr &&  bus_addr[5] && (bus_addr[4:2] == 3'd0);

    // R3
    cnt0_never_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_word0[30:9] != 22'd0);

    // R3
    cnt1_never_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_word1[30:9] != 22'd0);

    // R9
    irq_lo_rise_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_lo) |-> $past(tick));

    // R9
    irq_hi_rise_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_hi) |-> $past(tick));

    // R10
    cnt0_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(tick) && !$past(bus_wr)) |-> $stable(cnt_word0[30:9]));

    // R10
    cnt1_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(tick) && !$past(bus_wr)) |-> $stable(cnt_word1[30:9]));

    // R8
    lo_read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(t0_lim_rd) && !$past(tick)) |-> !irq_lo);

    // R8
    hi_read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(t1_lim_rd) && !$past(tick)) |-> !irq_hi);

    // R6
    lim0_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(t0_lim_wr) |-> (cnt_word0[30:11] == 20'd0 && $countones(cnt_word0[10:9]) == 1));

    // R6
    lim1_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(t1_lim_wr) |-> (cnt_word1[30:11] == 20'd0 && $countones(cnt_word1[10:9]) == 1));

endmodule

bind tmr_limit_pair tmr_limit_pair_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .irq_lo    (irq_lo),
    .irq_hi    (irq_hi),
    .tick      (tick),
    .cnt_word0 (cnt_word0),
    .cnt_word1 (cnt_word1)
);

// File: tb/sim_tmr_limit_pair.sv
// Bench for tmr_limit_pair: a cycle model built from the requirements, fed
// by directed cases and seeded random traffic. CLK_HZ is set so DIV = 4.
module sim_tmr_limit_pair;

    localparam int DIV = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_lo, irq_hi;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    string pend_tag = "R8";

    always #2.5 clk = ~clk;

    tmr_limit_pair #(.CLK_HZ(4_000_000), .FINE(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_lo(irq_lo), .irq_hi(irq_hi)
    );

    // Reference model state
    int          m_pre;
    logic [20:0] m_cnt [2];
    logic [20:0] m_lim [2];
    bit          m_flag [2];
    bit          m_run [2];
    bit          m_um [2];

    // Model update at each rising edge from the inputs driven at the negedge
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_pre = 0;
            for (int i = 0; i < 2; i++) begin
                m_cnt[i] = 21'd1; m_lim[i] = '0; m_flag[i] = 0;
                m_run[i] = 0; m_um[i] = 0;
            end
        end else begin
            bit tk;
            tk = (m_pre == DIV - 1);
            m_pre = tk ? 0 : m_pre + 1;
            for (int i = 0; i < 2; i++) begin
                bit hit, act, atl, ev, lwr;
                logic [2:0] w;
                hit = (bus_addr[5] == i[0]);
                w   = bus_addr[4:2];
                lwr = hit && bus_wr && (w == 3'd0);
                act = (m_lim[i] != 0) && (!m_um[i] || m_run[i]);
                atl = ({1'b0, m_cnt[i]} + 22'd1) >= {1'b0, m_lim[i]};
                ev  = tk && act && atl && !lwr;
                if (ev) m_flag[i] = 1;
                else if (hit && bus_rd && (w == 3'd0 || w == 3'd2)) m_flag[i] = 0;
                if (lwr) m_cnt[i] = 21'd1;
                else if (tk && act) m_cnt[i] = atl ? 21'd1 : m_cnt[i] + 21'd1;
                if (hit && bus_wr && (w == 3'd0 || w == 3'd2)) m_lim[i] = bus_wdata[30:10];
                if (hit && bus_wr && w == 3'd3) m_run[i] = bus_wdata[0];
                if (hit && bus_wr && w == 3'd4) m_um[i] = bus_wdata[0];
            end
        end
    end

    // Expected read data for the current address
    function automatic logic [31:0] exp_rdata(logic [5:0] a);
        int s;
        s = a[5];
        case (a[4:2])
            3'd0, 3'd2: return {m_flag[s], m_lim[s], 10'd0};
            3'd1:       return {m_flag[s], m_cnt[s], 10'd0};
            3'd3:       return {31'd0, m_run[s]};
            3'd4:       return {31'd0, m_um[s]};
            default:    return 32'd0;
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s cycle %0d: actual %h expected %h", tag, cyc, act, exp);
        end
    endtask

    // One cycle: check outputs at the negedge, then drive the next inputs
    task automatic drive(input bit rd, input bit wr, input logic [5:0] a,
                         input logic [31:0] d, input string tag);
        @(negedge clk);
        check(irq_lo == m_flag[0], "R9 irq_lo", {31'd0, irq_lo}, {31'd0, m_flag[0]});
        check(irq_hi == m_flag[1], "R9 irq_hi", {31'd0, irq_hi}, {31'd0, m_flag[1]});
        if (bus_rd)
            check(bus_rdata == exp_rdata(bus_addr), pend_tag, bus_rdata, exp_rdata(bus_addr));
        bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = d; pend_tag = tag;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) drive(0, 0, 6'd0, 32'd0, "R3");
    endtask

    function automatic logic [5:0] adr(input int t, input int w);
        return {t[0], w[2:0], 2'b00};
    endfunction

    function automatic logic [31:0] limw(input int v);
        return {1'b0, v[20:0], 10'd0};
    endfunction

    // Watchdog: an expired run counts as a failure and still summarises
    initial begin
        #(5ns * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired at cycle %0d: actual running expected done", cyc);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset values of every word of both timers
        for (int t = 0; t < 2; t++)
            for (int w = 0; w < 5; w++)
                drive(1, 0, adr(t, w == 0 ? 1 : w), 32'd0, "R1");
        // R4: limit 0 keeps the count at 1
        idle(20);
        drive(1, 0, adr(0, 1), 32'd0, "R4");
        drive(1, 0, adr(1, 1), 32'd0, "R4");
        // R6: limit 5 on timer 0 restarts the count
        drive(0, 1, adr(0, 0), limw(5), "R6");
        drive(1, 0, adr(0, 1), 32'd0, "R6");
        // R2: count advances once per DIV cycles
        for (int k = 0; k < 6; k++) begin
            drive(1, 0, adr(0, 1), 32'd0, "R2");
            idle(DIV - 1);
        end
        // R3 and R9: wrap events for a few periods, packing R5
        idle(40);
        drive(1, 0, adr(0, 1), 32'd0, "R5");
        drive(1, 0, adr(0, 1), 32'd0, "R8");
        // R8: limit read clears the flag, alias read too
        drive(1, 0, adr(0, 0), 32'd0, "R8");
        idle(16);
        drive(1, 0, adr(0, 2), 32'd0, "R8");
        // R7: alias write keeps the count
        drive(0, 1, adr(1, 0), limw(1000), "R6");
        idle(30);
        drive(1, 0, adr(1, 1), 32'd0, "R7");
        drive(0, 1, adr(1, 2), limw(9), "R7");
        drive(1, 0, adr(1, 1), 32'd0, "R7");
        drive(1, 0, adr(1, 2), 32'd0, "R7");
        // R10: user mode with run 0 holds, run 1 resumes
        drive(0, 1, adr(1, 4), 32'd1, "R10");
        drive(1, 0, adr(1, 4), 32'd0, "R10");
        drive(1, 0, adr(1, 1), 32'd0, "R10");
        idle(30);
        drive(1, 0, adr(1, 1), 32'd0, "R10");
        drive(0, 1, adr(1, 3), 32'd1, "R10");
        idle(30);
        drive(1, 0, adr(1, 1), 32'd0, "R10");
        drive(1, 0, adr(1, 3), 32'd0, "R10");
        // R11: unused words and count word writes change nothing
        drive(0, 1, adr(0, 6), 32'hFFFF_FFFF, "R11");
        drive(0, 1, adr(0, 1), 32'hFFFF_FFFF, "R11");
        drive(1, 0, adr(0, 6), 32'd0, "R11");
        drive(1, 0, adr(0, 5), 32'd0, "R11");
        drive(1, 0, adr(0, 0), 32'd0, "R11");
        // Seeded random traffic with small limits
        for (int k = 0; k < 4000; k++) begin
            int r, t, w;
            r = $urandom % 16;
            t = $urandom % 2;
            if (r < 6)
                drive(0, 0, 6'd0, 32'd0, "R3");
            else if (r < 10) begin
                w = $urandom % 8;
                drive(1, 0, adr(t, w), 32'd0, w == 1 ? "R3" : (w >= 5 ? "R11" : (w >= 3 ? "R10" : "R8")));
            end else if (r < 11)
                drive(0, 1, adr(t, 0), limw($urandom % 10), "R6");
            else if (r < 12)
                drive(0, 1, adr(t, 2), limw($urandom % 10), "R7");
            else if (r < 14)
                drive(0, 1, adr(t, 3), $urandom, "R10");
            else if (r < 15)
                drive(0, 1, adr(t, 4), $urandom, "R10");
            else
                drive(0, 1, adr(t, 5 + $urandom % 3), $urandom, "R11");
        end
        idle(2);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule